// File: doc/BRIEF.md
# Carry completion sensing adder

This block adds two unsigned words and a carry-in over several clock cycles. The number of cycles depends on the operands. Each bit position keeps its carry in a two-wire code. One register says the carry out of that position is known to be 1. A second register says it is known to be 0. When both are low, the carry is not yet known. On every clock edge a position whose two operand bits are equal settles by itself. A position whose operand bits differ copies the code of the position below it. A known carry therefore climbs one bit per cycle through a run of propagating positions.

As soon as every position holds a known carry, the adder flags completion. It then latches the sum, the carry-out and the number of update cycles it used. For random operands the longest propagate run is short, so the average number of cycles stays small even for wide words. The worst case, where every position propagates, costs one cycle per bit.

A caller pulses `start_i` with the operands present, then waits for `done_o`. The block registers the operands internally, so the input pins may change after the start cycle.

Top module: `ccs_adder`

## Requirements
- R1: While reset is held and after it is released, `done_o`, `sum_o`, `cout_o` and `cycles_o` are all 0 and the adder is idle.
- R2: When the adder is idle, a start pulse is accepted at the clock edge. That edge registers `a_i`, `b_i` and `cin_i`, clears every carry code to unknown (both rails 0), and drops `done_o` from the following cycle. Later changes on the operand pins have no effect on the result.
- R3: On each update edge, every position is recomputed at once from the previous cycle's values. The rules are:
  - Equal operand bits give (known-1, known-0) = (a, not a).
  - Differing bits copy the code of position i-1.
  - Position 0 uses (cin, not cin) as its lower neighbour.
  - No position ever has both rails set.
  - A position, once it is known, stays known until the next start.
- R4: Completion is the condition that every position has at least one rail set. `done_o` rises on the clock edge after the first cycle in which completion holds.
- R5: When `done_o` is high, {`cout_o`, `sum_o`} equals A + B + cin, computed WIDTH+1 bits wide.
- R6: `cycles_o` reports the number of update edges needed. It is the maximum of 1 and, over every maximal run of positions with differing operand bits, the run length. One is added to a run's length when the run does not start at bit 0.
- R7: If every operand bit pair differs, the adder takes exactly WIDTH cycles. If no pair differs, it takes exactly 1 cycle.
- R8: A start pulse that arrives while the adder is busy is ignored. The result and the cycle count still belong to the accepted operands.
- R9: After completion, `done_o`, `sum_o`, `cout_o` and `cycles_o` hold their values until the next accepted start.
- R10: `done_o` is low in every cycle in which an addition is in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start pulse; sampled only when idle |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| cin_i | input | 1 | Carry-in |
| sum_o | output | WIDTH | Latched sum |
| cout_o | output | 1 | Latched carry-out |
| done_o | output | 1 | High once the latched result is valid |
| cycles_o | output | CNT_W | Update cycles used by the last addition |

## Verification
The bench builds the adder at its default WIDTH of 16. At that width the full range of propagate-run lengths, from none up to all sixteen, can be placed at every offset. This covers both the single-cycle case and the full-width worst case. A sweep sets each run length at a random position inside otherwise random operands. The same sweep exercises the extra cycle charged to a run that does not start at bit 0. A second start pulse is issued in the middle of a full-width run to confirm that it is dropped.

// File: rtl/ccs_pkg.sv
package ccs_pkg;

  // Two-wire carry code: c = carry known to be 1, n = carry known to be 0.
  typedef struct packed {
    logic c;
    logic n;
  } rail_t;

  localparam rail_t RAIL_UNKNOWN = '{c: 1'b0, n: 1'b0};

  // Code of a carry whose value is already certain.
  function automatic rail_t rail_resolved(input logic value);
    rail_t r;
    r.c = value;
    r.n = ~value;
    return r;
  endfunction

endpackage

// File: rtl/ccs_rst_sync.sv
module ccs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sn = sync_q[1];

endmodule

// File: rtl/ccs_rail_slice.sv
module ccs_rail_slice
  import ccs_pkg::*;
(
  input  logic  a_bit,
  input  logic  b_bit,
  input  rail_t below,
  output rail_t next_rail
);

  // Equal bits fix the carry-out by themselves; differing bits pass the
  // lower neighbour's code upward.
  always_comb begin
    if (a_bit == b_bit) begin
      next_rail = rail_resolved(a_bit);
    end else begin
      next_rail = below;
    end
  end

endmodule

// File: rtl/ccs_complete_detect.sv
module ccs_complete_detect #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] rail_c,
  input  logic [WIDTH-1:0] rail_n,
  output logic             all_known
);

  logic [WIDTH-1:0] known_w;

  assign known_w   = rail_c | rail_n;
  assign all_known = &known_w;

endmodule

// File: rtl/ccs_step_counter.sv
module ccs_step_counter #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_sn,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] step
);

  logic [CNT_W-1:0] step_d;
  logic [CNT_W-1:0] step_q;

  always_comb begin
    step_d = step_q;
    if (clr) begin
      step_d = '0;
    end else if (en) begin
      step_d = step_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      step_q <= '0;
    end else begin
      step_q <= step_d;
    end
  end

  assign step = step_q;

endmodule

// File: rtl/ccs_adder.sv
module ccs_adder
  import ccs_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             done_o,
  output logic [CNT_W-1:0] cycles_o
);

  localparam int MSB = WIDTH - 1;

  logic rst_sn;

  // state registers
  logic             busy_q,  busy_d;
  logic             done_q,  done_d;
  logic [WIDTH-1:0] a_q,     a_d;
  logic [WIDTH-1:0] b_q,     b_d;
  logic             cin_q,   cin_d;
  logic [WIDTH-1:0] rc_q,    rc_d;
  logic [WIDTH-1:0] rn_q,    rn_d;
  logic [WIDTH-1:0] sum_q,   sum_d;
  logic             cout_q,  cout_d;
  logic [CNT_W-1:0] cyc_q,   cyc_d;

  // datapath nets
  rail_t            below_w [WIDTH];
  rail_t            next_w  [WIDTH];
  logic [WIDTH-1:0] rc_nx;
  logic [WIDTH-1:0] rn_nx;
  logic [WIDTH-1:0] carry_in_w;
  logic [WIDTH-1:0] sum_w;
  logic             all_known;
  logic             cnt_clr;
  logic             cnt_en;
  logic [CNT_W-1:0] step;

  ccs_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // one slice per bit; bit 0 takes the carry-in as its lower neighbour
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign below_w[i] = rail_resolved(cin_q);
    end else begin : g_up
      assign below_w[i] = {rc_q[i-1], rn_q[i-1]};
    end

    ccs_rail_slice u_slice (
      .a_bit     (a_q[i]),
      .b_bit     (b_q[i]),
      .below     (below_w[i]),
      .next_rail (next_w[i])
    );

    assign rc_nx[i]      = next_w[i].c;
    assign rn_nx[i]      = next_w[i].n;
    assign carry_in_w[i] = below_w[i].c;
  end

  assign sum_w = a_q ^ b_q ^ carry_in_w;

  ccs_complete_detect #(.WIDTH(WIDTH)) u_detect (
    .rail_c    (rc_q),
    .rail_n    (rn_q),
    .all_known (all_known)
  );

  ccs_step_counter #(.CNT_W(CNT_W)) u_count (
    .clk    (clk),
    .rst_sn (rst_sn),
    .clr    (cnt_clr),
    .en     (cnt_en),
    .step   (step)
  );

  // next-state logic
  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    a_d     = a_q;
    b_d     = b_q;
    cin_d   = cin_q;
    rc_d    = rc_q;
    rn_d    = rn_q;
    sum_d   = sum_q;
    cout_d  = cout_q;
    cyc_d   = cyc_q;
    cnt_clr = 1'b0;
    cnt_en  = 1'b0;
    if (busy_q) begin
      if (all_known) begin
        busy_d = 1'b0;
        done_d = 1'b1;
        sum_d  = sum_w;
        cout_d = rc_q[MSB];
        cyc_d  = step;
      end else begin
        rc_d   = rc_nx;
        rn_d   = rn_nx;
        cnt_en = 1'b1;
      end
    end else if (start_i) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      a_d     = a_i;
      b_d     = b_i;
      cin_d   = cin_i;
      rc_d    = {WIDTH{RAIL_UNKNOWN.c}};
      rn_d    = {WIDTH{RAIL_UNKNOWN.n}};
      cnt_clr = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      a_q    <= '0;
      b_q    <= '0;
      cin_q  <= 1'b0;
      rc_q   <= '0;
      rn_q   <= '0;
      sum_q  <= '0;
      cout_q <= 1'b0;
      cyc_q  <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      a_q    <= a_d;
      b_q    <= b_d;
      cin_q  <= cin_d;
      rc_q   <= rc_d;
      rn_q   <= rn_d;
      sum_q  <= sum_d;
      cout_q <= cout_d;
      cyc_q  <= cyc_d;
    end
  end

  assign sum_o    = sum_q;
  assign cout_o   = cout_q;
  assign done_o   = done_q;
  assign cycles_o = cyc_q;

endmodule

// File: rtl/ccs_adder_chk.sv
module ccs_adder_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = $clog2(WIDTH + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             busy,
  input logic [WIDTH-1:0] opa,
  input logic [WIDTH-1:0] opb,
  input logic             opcin,
  input logic [WIDTH-1:0] rc,
  input logic [WIDTH-1:0] rn,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             done_o,
  input logic [CNT_W-1:0] cycles_o
);

  logic [WIDTH:0] ref_total;
  assign ref_total = {1'b0, opa} + {1'b0, opb} + {{WIDTH{1'b0}}, opcin};

  // R2: an accepted start leaves every carry unknown in the next cycle
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy) |=> (rc == '0 && rn == '0 && busy));

  // R3: never both rails set
  a_r3_legal_code: assert property (@(posedge clk) disable iff (!rst_n)
    (rc & rn) == '0);

  // R3: a known position stays known during a run
  a_r3_monotone: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> (($past(rc | rn) & ~(rc | rn)) == '0));

  // R4: done rises only after every position was known
  a_r4_done_after_complete: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(&(rc | rn)));

  // R5: latched result equals the arithmetic sum of the held operands
  a_r5_sum_value: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> ({cout_o, sum_o} == ref_total));

  // R6: reported count lies between 1 and WIDTH
  a_r6_cycles_range: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> (cycles_o >= CNT_W'(1) && cycles_o <= CNT_W'(WIDTH)));

  // R8: a start while busy leaves the held operands alone
  a_r8_ignore_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> ($stable(opa) && $stable(opb) && $stable(opcin)));

  // R9: results hold while done stays high
  a_r9_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && $past(done_o)) |-> ($stable(sum_o) && $stable(cout_o) && $stable(cycles_o)));

  // R10: done low during a run
  a_r10_done_low_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !done_o);

endmodule

bind ccs_adder ccs_adder_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sn),
  .start_i  (start_i),
  .busy     (busy_q),
  .opa      (a_q),
  .opb      (b_q),
  .opcin    (cin_q),
  .rc       (rc_q),
  .rn       (rn_q),
  .sum_o    (sum_o),
  .cout_o   (cout_o),
  .done_o   (done_o),
  .cycles_o (cycles_o)
);

// File: tb/tb_ccs_adder.sv
`timescale 1ns/1ps
module tb_ccs_adder;

  localparam int W  = 16;
  localparam int CW = $clog2(W + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  a = '0;
  logic [W-1:0]  b = '0;
  logic          cin = 1'b0;
  logic [W-1:0]  sum;
  logic          cout;
  logic          done;
  logic [CW-1:0] cycles;

  always #5 clk = ~clk;

  ccs_adder #(.WIDTH(W)) dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (start),
    .a_i      (a),
    .b_i      (b),
    .cin_i    (cin),
    .sum_o    (sum),
    .cout_o   (cout),
    .done_o   (done),
    .cycles_o (cycles)
  );

  int n_chk = 0;
  int n_err = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // expected update cycles from propagate runs
  function automatic int exp_steps(input logic [W-1:0] x, input logic [W-1:0] y);
    int k = 1;
    int run = 0;
    int st = 0;
    for (int i = 0; i < W; i++) begin
      if (x[i] ^ y[i]) begin
        if (run == 0) st = i;
        run++;
        if (run + ((st > 0) ? 1 : 0) > k) k = run + ((st > 0) ? 1 : 0);
      end else begin
        run = 0;
      end
    end
    return k;
  endfunction

  // cycle-by-cycle reference model
  logic         m_busy, m_done, m_cout, p_cout;
  logic [W-1:0] m_sum, p_sum;
  int           m_left, m_cyc, p_cyc;
  logic [W:0]   tot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_cout = 0; m_sum = '0; m_cyc = 0; m_left = 0;
      p_cout = 0; p_sum = '0; p_cyc = 0;
    end else if (m_busy) begin
      m_left--;
      if (m_left == 0) begin
        m_busy = 0; m_done = 1;
        m_sum = p_sum; m_cout = p_cout; m_cyc = p_cyc;
      end
    end else if (start) begin
      m_busy = 1; m_done = 0;
      tot = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      p_sum = tot[W-1:0]; p_cout = tot[W];
      p_cyc = exp_steps(a, b);
      m_left = p_cyc + 1;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check(done === m_done, "R2 R4 R10", "done", 64'(done), 64'(m_done));
      if (m_done) begin
        check(sum === m_sum, "R5 R9", "sum", 64'(sum), 64'(m_sum));
        check(cout === m_cout, "R5 R9", "cout", 64'(cout), 64'(m_cout));
        check(int'(cycles) == m_cyc, "R3 R6", "cycles", 64'(cycles), 64'(m_cyc));
      end
    end
  end

  task automatic run_op(input logic [W-1:0] ta, input logic [W-1:0] tb, input logic tc);
    @(negedge clk);
    a = ta; b = tb; cin = tc; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    a = ~ta; b = ta; cin = ~tc;   // R2: pins change after capture
    while (!done) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] ra, rmask;
    int off;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(done == 1'b0, "R1", "done in reset", 64'(done), 0);
    check(sum == '0 && cout == 1'b0, "R1", "result in reset", 64'({cout, sum}), 0);
    check(cycles == '0, "R1", "cycles in reset", 64'(cycles), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(done == 1'b0 && cycles == '0, "R1", "idle after reset", 64'({done, cycles}), 0);

    // R7: all positions propagate
    run_op(16'hAAAA, 16'h5555, 1'b1);
    check(cycles == CW'(W), "R7", "full chain cin=1", 64'(cycles), 64'(W));
    check({cout, sum} == {1'b1, 16'h0000}, "R5", "full chain sum", 64'({cout, sum}), 64'h10000);
    run_op(16'h5555, 16'hAAAA, 1'b0);
    check(cycles == CW'(W), "R7", "full chain cin=0", 64'(cycles), 64'(W));
    check({cout, sum} == {1'b0, 16'hFFFF}, "R5", "full chain sum", 64'({cout, sum}), 64'hFFFF);
    // R7: no propagation
    run_op(16'h0000, 16'h0000, 1'b1);
    check(cycles == CW'(1), "R7", "no propagate", 64'(cycles), 1);
    run_op(16'hFFFF, 16'hFFFF, 1'b1);
    check(cycles == CW'(1), "R7", "all generate", 64'(cycles), 1);
    check({cout, sum} == {1'b1, 16'hFFFF}, "R5", "all generate sum", 64'({cout, sum}), 64'h1FFFF);
    // R6: run of 8 above bit 0 costs 9
    run_op(16'h0000, 16'h0FF0, 1'b0);
    check(cycles == CW'(9), "R6", "mid run", 64'(cycles), 9);

    // R8: start while busy is dropped
    @(negedge clk);
    a = 16'hAAAA; b = 16'h5555; cin = 1'b1; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (3) @(negedge clk);
    a = 16'h0001; b = 16'h0001; cin = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check({cout, sum} == {1'b1, 16'h0000}, "R8", "busy start result", 64'({cout, sum}), 64'h10000);
    check(cycles == CW'(W), "R8", "busy start cycles", 64'(cycles), 64'(W));
    // R9: hold after completion
    repeat (5) @(negedge clk);
    check(done && sum == 16'h0000 && cout, "R9", "hold", 64'({done, cout, sum}), 64'h30000);

    // R6: sweep of run lengths at random offsets
    for (int len = 0; len <= W; len++) begin
      off = (len == W) ? 0 : $urandom_range(W - len, 0);
      rmask = W'(((64'd1 << len) - 64'd1) << off);
      ra = W'($urandom);
      run_op(ra, ra ^ rmask, 1'($urandom));
    end
    // R5: random operands
    for (int k = 0; k < 300; k++) begin
      run_op(W'($urandom), W'($urandom), 1'($urandom));
    end

    finished = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule